// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block holds the interrupt status and interrupt mask of a peripheral controller and drives one level-sensitive interrupt line. One-cycle event pulses from the transfer engine latch into a sticky status register. Software reads that register and clears serviced bits by writing ones back to it. The mask cannot be written directly. Software unmasks sources by writing ones to an enable alias and masks them by writing ones to a disable alias.

Access is through a plain register port with a write strobe, a byte address, write data and combinational read data. All reads are free of side effects. The block has no stream interface and no back-pressure. Each write completes in the cycle its strobe is high.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status reads 0x000, the mask reads 0x2FF, and `irq_o` is low.
- R2: An event pulse on `evt_i[k]` sets status bit k at the next clock edge, and the bit stays set with no further pulses. The bit assignments are: 0 completion, 1 data threshold, 2 NACK, 3 timeout, 4 target ready, 5 RX overflow, 6 TX overflow, 7 RX underflow, 8 read-only flag, 9 spare.
- R3: A write to offset 0x10 clears every status bit whose write-data bit is 1 and lies in 0x2FF. Bits written as 0 are kept.
- R4: Status bit 8 cannot be cleared by any write. Once set, it is cleared only by reset.
- R5: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The mask at offset 0x20 is read-only. Writes to 0x20 leave the mask and the status unchanged.
- R7: A write to offset 0x24 clears each mask bit whose write-data bit is 1 and leaves the other mask bits as they were.
- R8: A write to offset 0x28 sets each mask bit whose write-data bit is 1 and leaves the other mask bits as they were.
- R9: `irq_o` is registered. In each cycle it equals the OR-reduction of (status AND NOT mask) as it was in the previous cycle.
- R10: Reads of 0x10 and 0x20 return their 10-bit value zero-extended. Reads of 0x24 and 0x28 return 0.
- R11: Reads of any other offset return 0. Writes to any other offset change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | STAT_W (10) | One-cycle event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (8) | Byte address for reads and writes |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for `addr_i` |
| irq_o | output | 1 | Level interrupt output |

## Verification
Several properties are checked on every clock cycle:
- status bits rise only where an event pulse occurred, and a pulsed bit is always set in the next cycle;
- the read-only flag never falls;
- the mask moves only on enable or disable writes;
- `irq_o` is low one cycle after status AND NOT mask was zero;
- the alias and undefined offsets read zero.

The exact bitwise effect of clear, enable and disable writes, and the set-over-clear priority, can only be shown by the bench's scenarios. The bench compares every read-back and every interrupt level against a reference model that runs alongside the design.

// File: rtl/isu_pkg.sv
`timescale 1ns/1ps
package isu_pkg;
  localparam int unsigned OFF_STATUS  = 32'h10;
  localparam int unsigned OFF_MASK    = 32'h20;
  localparam int unsigned OFF_ENABLE  = 32'h24;
  localparam int unsigned OFF_DISABLE = 32'h28;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/isu_decode.sv
`timescale 1ns/1ps
module isu_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_status_o,
  output logic              wr_enable_o,
  output logic              wr_disable_o,
  output isu_pkg::rd_sel_e  rd_sel_o
);
  import isu_pkg::*;

  logic hit_status, hit_mask, hit_enable, hit_disable;

  always_comb begin
    hit_status  = (addr_i == ADDR_W'(OFF_STATUS));
    hit_mask    = (addr_i == ADDR_W'(OFF_MASK));
    hit_enable  = (addr_i == ADDR_W'(OFF_ENABLE));
    hit_disable = (addr_i == ADDR_W'(OFF_DISABLE));

    wr_status_o  = wr_en_i & hit_status;
    wr_enable_o  = wr_en_i & hit_enable;
    wr_disable_o = wr_en_i & hit_disable;

    if (hit_status)    rd_sel_o = SEL_STATUS;
    else if (hit_mask) rd_sel_o = SEL_MASK;
    else               rd_sel_o = SEL_ZERO;
  end
endmodule

// File: rtl/isu_status.sv
`timescale 1ns/1ps
module isu_status #(
  parameter int unsigned      W        = 10,
  parameter logic [W-1:0]     CLR_MASK = 10'h2FF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_req_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_w1c
      always_ff @(posedge clk) begin
        if (!rst_n)                          stat_o[i] <= 1'b0;
        else if (evt_i[i])                   stat_o[i] <= 1'b1;
        else if (clr_req_i && clr_bits_i[i]) stat_o[i] <= 1'b0;
      end
    end else begin : g_ro
      always_ff @(posedge clk) begin
        if (!rst_n)        stat_o[i] <= 1'b0;
        else if (evt_i[i]) stat_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isu_mask.sv
`timescale 1ns/1ps
module isu_mask #(
  parameter int unsigned  W       = 10,
  parameter logic [W-1:0] RST_VAL = 10'h2FF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unmask_i,
  input  logic         setmask_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)         mask_o <= RST_VAL;
    else if (unmask_i)  mask_o <= mask_o & ~bits_i;
    else if (setmask_i) mask_o <= mask_o | bits_i;
  end
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit #(
  parameter int unsigned       STAT_W   = 10,
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [STAT_W-1:0] CLR_MASK = 10'h2FF,
  parameter logic [STAT_W-1:0] MASK_RST = 10'h2FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import isu_pkg::*;

  localparam int unsigned PAD_W = DATA_W - STAT_W;

  logic              wr_status, wr_enable, wr_disable;
  rd_sel_e           rd_sel;
  logic [STAT_W-1:0] stat_q, mask_q, wbits;
  logic              unused_hi;
  logic              irq_q;

  assign wbits     = wdata_i[STAT_W-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:STAT_W];

  isu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wr_status_o (wr_status),
    .wr_enable_o (wr_enable),
    .wr_disable_o(wr_disable),
    .rd_sel_o    (rd_sel)
  );

  isu_status #(.W(STAT_W), .CLR_MASK(CLR_MASK)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_req_i (wr_status),
    .clr_bits_i(wbits),
    .stat_o    (stat_q)
  );

  isu_mask #(.W(STAT_W), .RST_VAL(MASK_RST)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .unmask_i (wr_enable),
    .setmask_i(wr_disable),
    .bits_i   (wbits),
    .mask_o   (mask_q)
  );

  always_comb begin
    case (rd_sel)
      SEL_STATUS: rdata_o = {{PAD_W{1'b0}}, stat_q};
      SEL_MASK:   rdata_o = {{PAD_W{1'b0}}, mask_q};
      default:    rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_q & ~mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
`timescale 1ns/1ps
module irq_status_unit_chk #(
  parameter int unsigned STAT_W = 10,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] evt_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q
);
  import isu_pkg::*;

  logic mask_wr;
  logic alias_rd;
  assign mask_wr  = wr_en_i && (addr_i == ADDR_W'(OFF_ENABLE) || addr_i == ADDR_W'(OFF_DISABLE));
  assign alias_rd = (addr_i == ADDR_W'(OFF_ENABLE)) || (addr_i == ADDR_W'(OFF_DISABLE));

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(stat_q[8])); // R4
  AST_MASK_ONLY_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~mask_q) == '0) |=> !irq_o); // R9
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    alias_rd |-> (rdata_o == '0)); // R10
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .STAT_W(STAT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .evt_i  (evt_i),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .stat_q (stat_q),
  .mask_q (mask_q)
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] stat_m = '0;
  logic [9:0] mask_m = 10'h2FF;

  always #2.5 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a == 8'h10) return {22'd0, stat_m};
    if (a == 8'h20) return {22'd0, mask_m};
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] ev, input logic we, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic irq_exp;
    logic [9:0] clr;
    @(negedge clk);
    evt = ev; wr_en = we; addr = a; wdata = d;
    irq_exp = |(stat_m & ~mask_m);
    clr = (we && a == 8'h10) ? (d[9:0] & 10'h2FF) : 10'h000;
    stat_m = (stat_m & ~clr) | ev;
    if (we && a == 8'h24)      mask_m = mask_m & ~d[9:0];
    else if (we && a == 8'h28) mask_m = mask_m | d[9:0];
    @(posedge clk);
    #1;
    chk({tag, " R9 irq"}, {31'd0, irq}, {31'd0, irq_exp});
    evt = '0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    evt = '0; wr_en = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] offs [6];
    offs[0] = 8'h10; offs[1] = 8'h20; offs[2] = 8'h24;
    offs[3] = 8'h28; offs[4] = 8'h14; offs[5] = 8'h2C;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, "R1 status");
    rd(8'h20, "R1 mask");
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2/R9: unmask completion, raise event, irq one cycle late
    step(10'h000, 1'b1, 8'h24, 32'h0000_0001, "R7 enable");
    rd(8'h20, "R7 mask after enable");
    step(10'h001, 1'b0, 8'h00, 32'h0, "R2 event");
    rd(8'h10, "R2 status bit0");
    step(10'h000, 1'b0, 8'h00, 32'h0, "R9 one cycle later");
    chk("R9 irq high", {31'd0, irq}, 32'd1);

    // R3 clear only written ones; R5 set wins
    step(10'h0C2, 1'b0, 8'h00, 32'h0, "R2 multi event");
    step(10'h000, 1'b1, 8'h10, 32'h0000_0041, "R3 w1c");
    rd(8'h10, "R3 status after w1c");
    step(10'h002, 1'b1, 8'h10, 32'h0000_0002, "R5 collide");
    rd(8'h10, "R5 set wins");

    // R4 bit 8 sticky, bit 9 clears
    step(10'h300, 1'b0, 8'h00, 32'h0, "R4 event");
    step(10'h000, 1'b1, 8'h10, 32'hFFFF_FFFF, "R4 clear all");
    rd(8'h10, "R4 flag kept");

    // R6 mask direct write ignored; R8 disable
    step(10'h000, 1'b1, 8'h20, 32'h0000_0000, "R6 direct write");
    rd(8'h20, "R6 mask unchanged");
    step(10'h000, 1'b1, 8'h28, 32'h0000_0001, "R8 disable");
    rd(8'h20, "R8 mask after disable");

    // R10 / R11 reads and ignored writes
    rd(8'h24, "R10 enable reads 0");
    rd(8'h28, "R10 disable reads 0");
    step(10'h000, 1'b1, 8'h14, 32'hFFFF_FFFF, "R11 undefined write");
    step(10'h000, 1'b1, 8'h2C, 32'h0000_0000, "R11 undefined write");
    rd(8'h14, "R11 undefined reads 0");
    rd(8'h10, "R11 status unchanged");
    rd(8'h20, "R11 mask unchanged");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [9:0] ev;
      ev = (($urandom % 4) == 0) ? 10'(1 << ($urandom % 10)) : 10'h000;
      step(ev, 1'($urandom % 2), offs[$urandom % 6], $urandom, "R3 random");
      rd(offs[$urandom % 6], "R10 random read");
    end

    finish_run();
  end
endmodule